// File: doc/BRIEF.md
# Link Bring-up Speed Sequencer

This block is the control sequencer that brings a serial link up at the lowest speed and then moves it to a faster one. When `start` is pulsed, it first rewrites the maximum-speed field of a link capability register so that only first-generation operation is allowed. It then enables the link training logic and polls the link-up indication a bounded number of times. After the link is up, it rewrites the same field to allow second-generation operation. It sets a self-clearing directed speed-change bit and polls that bit until it clears. It then waits for the link to be up again. Last, it reads the link status word to learn which generation was negotiated.

Every register update is a read-modify-write through a simple request/acknowledge register port, so bits outside the target field are written back unchanged. The outcome is a single-cycle `done` pulse. `pass` is high in that cycle on success. `gen` carries the negotiated generation and holds it until the next start. Poll counts and poll spacing are parameters. The training logic, the clocks and the reset lines are outside this block.

Top module: `link_speed_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `busReq`, `trainEn`, `done` and `pass` are 0 and `gen` is 0. While idle no bus request is made.
- R2: On start the block first reads the capability register at `CAP_ADDR`. It writes it back with bits [3:0] set to 1 and all other bits unchanged. This write completes while `trainEn` is still 0.
- R3: `trainEn` rises only in the cycle after the acknowledge of that first capability write. It stays high until the next accepted start, which clears it.
- R4: Link wait: `linkUp` is sampled at most `MAX_POLLS` times. Samples are spaced `POLL_WAIT`+1 cycles apart, and the first sample falls in the first cycle with `trainEn` high. If no sample sees it high, the run fails.
- R5: After the first link-up, the capability register is read again. It is written back with bits [3:0] set to 2, while `linkUp` is high and with all other bits unchanged.
- R6: The control register at `CTRL_ADDR` is then read and written back with bit 17 set and all other bits unchanged.
- R7: Bit 17 of `CTRL_ADDR` is read back at most `MAX_POLLS` times, with `POLL_WAIT` idle cycles between reads. If every read shows it set, the run fails.
- R8: After bit 17 reads clear, a second link wait runs under the same rule as R4. If the link is not seen up in that wait, the run fails.
- R9: On success the status word at `STAT_ADDR` is read, and `gen` takes its bits [19:16] with `pass`=1.
- R10: `done` is a one-cycle pulse, and `pass` is high only together with `done`. `gen` clears to 0 in the cycle after an accepted start and stays 0 on failure. Otherwise it holds its value until the next accepted start.
- R11: Once `busReq` is raised, it stays high with `busWr`, `busAddr` and `busWdata` unchanged until `busAck` is seen.
- R12: A `start` pulse while `busy` is 1 is ignored. The run in progress completes with the same result and the same number of capability writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse to begin a bring-up sequence |
| linkUp | input | 1 | Link-up indication from the training logic |
| busReq | output | 1 | Register port request, held until acknowledged |
| busWr | output | 1 | 1 = write, 0 = read |
| busAddr | output | ADDR_W | Register address |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, valid with `busAck` |
| busAck | input | 1 | One-cycle completion of the request |
| trainEn | output | 1 | Enables link training |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| pass | output | 1 | Success flag, valid with `done` |
| gen | output | 4 | Negotiated generation |

## Verification
The bench sweeps the delay before the link comes up across the edge of the poll window. It checks the cases where the link rises exactly on the last allowed sample and one cycle after it. A sequencer with an off-by-one poll limit or poll spacing would pass or fail the wrong runs. The number of reads for which the speed-change bit stays set is swept the same way. The link is also dropped after the speed change, which catches a design that skips the second link wait. The register model flags a Gen1 write that lands after training was enabled, a Gen2 write made before link-up, and any change to bits outside the target field.

// File: rtl/link_speed_seq_pkg.sv
package link_speed_seq_pkg;
  localparam int SPD_W   = 4;
  localparam int CHG_BIT = 17;
  localparam int GEN_LSB = 16;

  typedef enum logic [1:0] {MOD_GEN1, MOD_GEN2, MOD_CHG} modSel_e;

  typedef struct packed {
    logic    capture;
    modSel_e modSel;
    logic    cntClr;
    logic    cntInc;
    logic    tmrLoad;
    logic    genClr;
    logic    genLd;
  } dpStrobe_t;

  typedef struct packed {
    logic cntLast;
    logic tmrDone;
    logic chgBusy;
  } dpFlag_t;
endpackage

// File: rtl/link_speed_seq_dp.sv
module link_speed_seq_dp
  import link_speed_seq_pkg::*;
#(
  parameter int MAX_POLLS = 200,
  parameter int POLL_WAIT = 12500
) (
  input  logic        clk,
  input  logic        rst,
  input  dpStrobe_t   stb,
  input  logic        busAck,
  input  logic [31:0] busRdata,
  output logic [31:0] busWdata,
  output logic [3:0]  gen,
  output dpFlag_t     flg
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam int TMR_W = (POLL_WAIT > 1) ? $clog2(POLL_WAIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_POLLS - 1);
  localparam logic [TMR_W-1:0] TMR_INIT = (POLL_WAIT > 0) ? TMR_W'(POLL_WAIT - 1) : '0;

  logic [31:0]      dataReg;
  logic [CNT_W-1:0] pollCnt;
  logic [TMR_W-1:0] waitTmr;
  logic [3:0]       genReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg <= '0;
      pollCnt <= '0;
      waitTmr <= '0;
      genReg  <= '0;
    end else begin
      if (stb.capture && busAck) dataReg <= busRdata;
      if (stb.cntClr)      pollCnt <= '0;
      else if (stb.cntInc) pollCnt <= pollCnt + 1'b1;
      if (stb.tmrLoad)          waitTmr <= TMR_INIT;
      else if (waitTmr != '0)   waitTmr <= waitTmr - 1'b1;
      if (stb.genClr)     genReg <= '0;
      else if (stb.genLd) genReg <= busRdata[GEN_LSB +: 4];
    end
  end

  always_comb begin
    unique case (stb.modSel)
      MOD_GEN1: busWdata = {dataReg[31:SPD_W], SPD_W'(1)};
      MOD_GEN2: busWdata = {dataReg[31:SPD_W], SPD_W'(2)};
      MOD_CHG:  busWdata = dataReg | (32'd1 << CHG_BIT);
      default:  busWdata = dataReg;
    endcase
  end

  assign flg.cntLast = (pollCnt == CNT_LAST);
  assign flg.tmrDone = (waitTmr == '0);
  assign flg.chgBusy = busRdata[CHG_BIT];
  assign gen         = genReg;
endmodule

// File: rtl/link_speed_seq_ctrl.sv
module link_speed_seq_ctrl
  import link_speed_seq_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter int              POLL_WAIT = 12500,
  parameter logic [ADDR_W-1:0] CAP_ADDR  = 'h07C,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h80C,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              linkUp,
  input  logic              busAck,
  input  dpFlag_t           flg,
  output dpStrobe_t         stb,
  output logic              busReq,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic              trainEn,
  output logic              busy,
  output logic              done,
  output logic              pass
);
  typedef enum logic [3:0] {
    S_IDLE, S_CAP1_RD, S_CAP1_WR, S_LW_CHK, S_LW_WAIT,
    S_CAP2_RD, S_CAP2_WR, S_CHG_RD, S_CHG_WR,
    S_SC_RD, S_SC_WAIT, S_STAT_RD
  } state_e;

  state_e state, nextState;
  logic   secondWait;
  logic   setTrain, clrTrain, setSecond, finOk, finFail;

  always_comb begin
    nextState = state;
    stb       = '0;
    stb.modSel = MOD_GEN1;
    busReq    = 1'b0;
    busWr     = 1'b0;
    busAddr   = '0;
    setTrain  = 1'b0;
    clrTrain  = 1'b0;
    setSecond = 1'b0;
    finOk     = 1'b0;
    finFail   = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        stb.genClr = 1'b1;
        clrTrain   = 1'b1;
        nextState  = S_CAP1_RD;
      end
      S_CAP1_RD: begin
        busReq = 1'b1; busAddr = CAP_ADDR; stb.capture = 1'b1;
        if (busAck) nextState = S_CAP1_WR;
      end
      S_CAP1_WR: begin
        busReq = 1'b1; busWr = 1'b1; busAddr = CAP_ADDR; stb.modSel = MOD_GEN1;
        if (busAck) begin
          setTrain = 1'b1; stb.cntClr = 1'b1; nextState = S_LW_CHK;
        end
      end
      S_LW_CHK: begin
        if (linkUp) begin
          stb.cntClr = 1'b1;
          nextState  = secondWait ? S_STAT_RD : S_CAP2_RD;
        end else if (flg.cntLast) begin
          finFail = 1'b1; nextState = S_IDLE;
        end else begin
          stb.cntInc = 1'b1; stb.tmrLoad = 1'b1;
          nextState  = (POLL_WAIT > 0) ? S_LW_WAIT : S_LW_CHK;
        end
      end
      S_LW_WAIT: if (flg.tmrDone) nextState = S_LW_CHK;
      S_CAP2_RD: begin
        busReq = 1'b1; busAddr = CAP_ADDR; stb.capture = 1'b1;
        if (busAck) nextState = S_CAP2_WR;
      end
      S_CAP2_WR: begin
        busReq = 1'b1; busWr = 1'b1; busAddr = CAP_ADDR; stb.modSel = MOD_GEN2;
        if (busAck) nextState = S_CHG_RD;
      end
      S_CHG_RD: begin
        busReq = 1'b1; busAddr = CTRL_ADDR; stb.capture = 1'b1;
        if (busAck) nextState = S_CHG_WR;
      end
      S_CHG_WR: begin
        busReq = 1'b1; busWr = 1'b1; busAddr = CTRL_ADDR; stb.modSel = MOD_CHG;
        if (busAck) begin
          stb.cntClr = 1'b1; nextState = S_SC_RD;
        end
      end
      S_SC_RD: begin
        busReq = 1'b1; busAddr = CTRL_ADDR;
        if (busAck) begin
          if (!flg.chgBusy) begin
            stb.cntClr = 1'b1; setSecond = 1'b1; nextState = S_LW_CHK;
          end else if (flg.cntLast) begin
            finFail = 1'b1; nextState = S_IDLE;
          end else begin
            stb.cntInc = 1'b1; stb.tmrLoad = 1'b1;
            nextState  = (POLL_WAIT > 0) ? S_SC_WAIT : S_SC_RD;
          end
        end
      end
      S_SC_WAIT: if (flg.tmrDone) nextState = S_SC_RD;
      S_STAT_RD: begin
        busReq = 1'b1; busAddr = STAT_ADDR;
        if (busAck) begin
          stb.genLd = 1'b1; finOk = 1'b1; nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      secondWait <= 1'b0;
      trainEn    <= 1'b0;
      done       <= 1'b0;
      pass       <= 1'b0;
    end else begin
      state <= nextState;
      done  <= finOk | finFail;
      pass  <= finOk;
      if (clrTrain)      trainEn <= 1'b0;
      else if (setTrain) trainEn <= 1'b1;
      if (setTrain)       secondWait <= 1'b0;
      else if (setSecond) secondWait <= 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
  import link_speed_seq_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter int              MAX_POLLS = 200,
  parameter int              POLL_WAIT = 12500,
  parameter logic [ADDR_W-1:0] CAP_ADDR  = 'h07C,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h80C,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              linkUp,
  output logic              busReq,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  input  logic [31:0]       busRdata,
  input  logic              busAck,
  output logic              trainEn,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [3:0]        gen
);
  dpStrobe_t stb;
  dpFlag_t   flg;

  link_speed_seq_ctrl #(
    .ADDR_W(ADDR_W), .POLL_WAIT(POLL_WAIT),
    .CAP_ADDR(CAP_ADDR), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) i_ctrl (
    .clk(clk), .rst(rst), .start(start), .linkUp(linkUp), .busAck(busAck),
    .flg(flg), .stb(stb), .busReq(busReq), .busWr(busWr), .busAddr(busAddr),
    .trainEn(trainEn), .busy(busy), .done(done), .pass(pass)
  );

  link_speed_seq_dp #(.MAX_POLLS(MAX_POLLS), .POLL_WAIT(POLL_WAIT)) i_dp (
    .clk(clk), .rst(rst), .stb(stb), .busAck(busAck), .busRdata(busRdata),
    .busWdata(busWdata), .gen(gen), .flg(flg)
  );
endmodule

// File: rtl/link_speed_seq_chk.sv
module link_speed_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busReq,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              busAck,
  input logic              trainEn,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [3:0]        gen
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst) !busy |-> !busReq); // R1
  AST_TRAIN_AFTER_WR: assert property (@(posedge clk) disable iff (rst) $rose(trainEn) |-> $past(busAck && busWr)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (rst) pass |-> done); // R10
  AST_GEN_HOLD: assert property (@(posedge clk) disable iff (rst) (gen != $past(gen)) |-> (done || $past(start))); // R10
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst) (busReq && !busAck) |=> (busReq && $stable(busWr) && $stable(busAddr) && $stable(busWdata))); // R11
endmodule

bind link_speed_seq link_speed_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .start(start), .busReq(busReq), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck), .trainEn(trainEn),
  .busy(busy), .done(done), .pass(pass), .gen(gen)
);

// File: tb/test_link_speed_seq.sv
module test_link_speed_seq;
  localparam int AW = 12;
  localparam int MP = 4;
  localparam int PW = 3;
  localparam logic [AW-1:0] CAP_A  = 'h07C;
  localparam logic [AW-1:0] CTRL_A = 'h80C;
  localparam logic [AW-1:0] STAT_A = 'h080;

  logic clk = 0, rst = 1, start = 0;
  logic busReq, busWr, busAck, trainEn, busy, done, pass;
  logic [AW-1:0] busAddr;
  logic [31:0] busWdata, busRdata;
  logic [3:0] gen;
  logic linkUp;

  int nChk = 0, nBad = 0;
  int upDelay = 0, scHold = 0, lat = 0;
  bit dropLink = 0;
  logic [31:0] capInit = 32'hA5A5_C3FF, ctrlInit = 32'h1234_5678, statInit = 32'h0002_0C40;

  logic [31:0] capReg, ctrlReg, statReg;
  int tcnt, scLeft, lcnt, capWrites;
  bit dropNow, orderBad;

  always #5 clk = ~clk;

  link_speed_seq #(.ADDR_W(AW), .MAX_POLLS(MP), .POLL_WAIT(PW),
    .CAP_ADDR(CAP_A), .CTRL_ADDR(CTRL_A), .STAT_ADDR(STAT_A)) i_link_speed_seq (
    .clk(clk), .rst(rst), .start(start), .linkUp(linkUp), .busReq(busReq),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busAck(busAck), .trainEn(trainEn), .busy(busy), .done(done), .pass(pass), .gen(gen));

  assign linkUp = trainEn && (tcnt >= upDelay) && !dropNow;

  always @(posedge clk) begin
    if (!trainEn) tcnt <= 0; else tcnt <= tcnt + 1;
    if (rst) begin
      busAck <= 0; busRdata <= '0; lcnt <= 0;
    end else begin
      busAck <= 0;
      if (start && !busy) begin
        capReg <= capInit; ctrlReg <= ctrlInit; statReg <= statInit;
        capWrites <= 0; orderBad <= 0; dropNow <= 0; scLeft <= 0;
      end else if (busReq && !busAck) begin
        if (lcnt >= lat) begin
          lcnt <= 0; busAck <= 1;
          if (busWr) begin
            if (busAddr == CAP_A) begin
              capReg <= busWdata; capWrites <= capWrites + 1;
              if (busWdata[3:0] == 4'd1 && trainEn) orderBad <= 1;
              if (busWdata[3:0] == 4'd2 && !linkUp) orderBad <= 1;
              if (busWdata[31:4] != capReg[31:4]) orderBad <= 1;
            end else if (busAddr == CTRL_A) begin
              ctrlReg <= busWdata;
              if (busWdata[17]) scLeft <= scHold;
            end else orderBad <= 1;
          end else begin
            if (busAddr == CAP_A) busRdata <= capReg;
            else if (busAddr == STAT_A) busRdata <= statReg;
            else if (busAddr == CTRL_A) begin
              if (ctrlReg[17] && scLeft == 0) begin
                busRdata <= ctrlReg & ~(32'd1 << 17);
                ctrlReg[17] <= 1'b0;
                dropNow <= dropLink;
              end else begin
                busRdata <= ctrlReg;
                if (ctrlReg[17]) scLeft <= scLeft - 1;
              end
            end else busRdata <= 32'hDEAD_BEEF;
          end
        end else lcnt <= lcnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runSeq(input int d, input int s, input bit drop, input int l, input bit midStart);
    int samp;
    bit link1Ok, scOk, expPass;
    logic [3:0] expGen, seenGen;
    logic [31:0] expCap, expCtrl;
    int waitCyc;
    upDelay = d; scHold = s; dropLink = drop; lat = l;
    samp = (d + PW) / (PW + 1);
    link1Ok = samp < MP;
    scOk = s < MP;
    expPass = link1Ok && scOk && !drop;
    expGen = expPass ? statInit[19:16] : 4'd0;
    expCap = {capInit[31:4], link1Ok ? 4'd2 : 4'd1};
    expCtrl = (link1Ok && !scOk) ? (ctrlInit | 32'h0002_0000) : ctrlInit;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check(gen == 4'd0 && busy, "R10 gen cleared on start", {28'd0, gen}, 0);
    if (midStart) begin
      repeat (3) @(negedge clk);
      start = 1; @(negedge clk) start = 0;
    end
    waitCyc = 0;
    while (!done && waitCyc < 4000) begin @(negedge clk); waitCyc++; end
    check(waitCyc < 4000, "R4 watchdog", waitCyc, 4000);
    check(pass == expPass, link1Ok ? (scOk ? "R8 final result" : "R7 speed-change timeout") : "R4 link wait", {31'd0, pass}, {31'd0, expPass});
    check(gen == expGen, "R9 generation", {28'd0, gen}, {28'd0, expGen});
    check(capReg == expCap, "R2 R5 capability field", capReg, expCap);
    check(ctrlReg == expCtrl, "R6 R7 control register", ctrlReg, expCtrl);
    check(!orderBad, "R2 R5 write ordering", {31'd0, orderBad}, 0);
    check(capWrites == (link1Ok ? 2 : 1), midStart ? "R12 start ignored while busy" : "R2 capability writes", capWrites, link1Ok ? 2 : 1);
    seenGen = gen;
    @(negedge clk);
    check(!done && !pass, "R10 done one cycle", {30'd0, done, pass}, 0);
    repeat (5) @(negedge clk);
    check(gen == seenGen && trainEn, "R10 R3 gen and trainEn held", {27'd0, trainEn, gen}, {27'd1, seenGen});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !busReq && !trainEn && !done && !pass && gen == 0, "R1 reset state",
          {26'd0, busy, busReq, trainEn, done, pass, 1'b0}, 0);
    rst = 0;
    @(negedge clk);
    check(!busReq && !busy, "R1 idle no request", {31'd0, busReq}, 0);
    for (int d = 0; d <= MP * (PW + 1) + 1; d++) runSeq(d, 1, 0, d % 3, 0);
    for (int s = 0; s <= MP + 1; s++) runSeq(2, s, 0, 1, 0);
    statInit = 32'hFFF1_FFFF;
    runSeq(0, 0, 0, 0, 0);
    runSeq(5, 2, 1, 2, 0);
    statInit = 32'h0002_0C40;
    runSeq(6, 1, 0, 1, 1);
    runSeq(20, 1, 0, 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule